// File: doc/BRIEF.md
# Vectored Interrupt Controller with Word-Addressed Register File

This block gathers a parameterised number of interrupt request lines, up to 32, and presents them to a processor as one combined interrupt output. Each line is fixed at build time as either edge-captured or level-following. Software sees and steers the lines through eight 32-bit word registers on a plain read/write strobe bus. The registers give the captured status, the pending (status and enable) view, the enable mask, and a vector holding the lowest-numbered pending line. There are separate write-only registers for acknowledging, for setting enable bits and for clearing enable bits, so software never needs a read-modify-write. A two-bit master register gates the output and arms acknowledges.

The bus carries a word index (byte offset divided by four), a write strobe with data, and a read strobe. Read data returns with a valid flag one clock after the read strobe. Software normally enables the lines it wants and sets both master bits. On an interrupt it reads the vector, services that line, acknowledges it by bitmask, and repeats until the vector reads all-ones.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the enable mask, both master bits and all status bits are zero, `irq_out` is low, `bus_rvalid` is low, and the vector register reads 0xFFFFFFFF.
- R2: A read strobe in one cycle yields `bus_rvalid` high and `bus_rdata` valid in the next cycle. The byte offsets are: status 0x00, pending 0x04, enable 0x08, acknowledge 0x0C, set-enable 0x10, clear-enable 0x14, vector 0x18, master 0x1C. The word index on `bus_waddr` is the offset divided by four.
- R3: A write to the enable register loads the mask, and writing zero disables every line. A write to set-enable sets exactly the bits that are one in the data. A write to clear-enable clears exactly the bits that are one in the data. In both cases all other bits are unchanged.
- R4: An edge-mode line sets its status bit in the cycle after a rising edge, and the bit stays set after the line falls until it is acknowledged. If a rising edge and an acknowledge of that line fall in the same cycle, the status bit stays set.
- R5: A level-mode line's status bit equals the line's value one cycle earlier. Acknowledging it clears the bit for one cycle only, so it returns while the line stays high.
- R6: Acknowledge bits written as one clear those status bits, bits written as zero have no effect, and all-ones clears every edge capture. While master bit 1 (acknowledge arm) is zero, acknowledge writes change nothing.
- R7: Pending equals status AND enable. `irq_out` is high exactly when master bit 0 is set and at least one pending bit is set.
- R8: The vector register reads the index of the lowest-numbered pending line, or 0xFFFFFFFF when no line is pending.
- R9: Master register bits 0 and 1 read back exactly as written, and its upper bits read zero.
- R10: Status, pending and enable bits at or above the implemented line count read zero. Writes to the status, pending and vector registers change no state. The acknowledge, set-enable and clear-enable registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | NUM_IN | Interrupt request lines, synchronous to clk |
| bus_waddr | input | 3 | Word index of the register accessed |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High one cycle after a read strobe |
| irq_out | output | 1 | Combined interrupt to the processor |

## Verification
The collision of interest is an acknowledge write landing in the same clock as a new rising edge on that edge-mode line. The bench drives the line high on the same clock edge where the acknowledge strobe for that bit is presented, then reads status and expects the bit still set. A second collision is an acknowledge of a level-mode line whose input is held high. There `irq_out` is judged cycle by cycle: it must drop for exactly one clock and then come back.

// File: rtl/vic_pkg.sv
package vic_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned WADDR_W = 3;

  typedef enum logic [WADDR_W-1:0] {
    RG_STAT   = 3'd0,
    RG_PEND   = 3'd1,
    RG_EN     = 3'd2,
    RG_ACK    = 3'd3,
    RG_SETEN  = 3'd4,
    RG_CLREN  = 3'd5,
    RG_VEC    = 3'd6,
    RG_MASTER = 3'd7
  } vic_reg_e;

  localparam logic [WORD_W-1:0] VEC_NONE = '1;

endpackage

// File: rtl/vic_capture.sv
module vic_capture #(
  parameter int unsigned NUM_IN    = 32,
  parameter logic [31:0] EDGE_MASK = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic [NUM_IN-1:0] ack_mask,
  output logic [NUM_IN-1:0] status
);

  for (genvar i = 0; i < NUM_IN; i++) begin : g_bit
    if (EDGE_MASK[i]) begin : g_edge
      logic prev_q;
      logic stat_q;
      logic stat_d;
      logic rise;

      always_comb begin
        rise   = irq_in[i] & ~prev_q;
        stat_d = (stat_q & ~ack_mask[i]) | rise;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
          stat_q <= 1'b0;
        end else begin
          prev_q <= irq_in[i];
          stat_q <= stat_d;
        end
      end

      assign status[i] = stat_q;

      AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (stat_q && !ack_mask[i]) |=> stat_q); // R4
    end else begin : g_level
      logic stat_q;
      logic stat_d;

      always_comb begin
        stat_d = irq_in[i] & ~ack_mask[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stat_q <= 1'b0;
        end else begin
          stat_q <= stat_d;
        end
      end

      assign status[i] = stat_q;

      AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n) !ack_mask[i] |=> (stat_q == $past(irq_in[i]))); // R5
    end
  end

endmodule

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
  parameter int unsigned NUM_IN = 32,
  localparam int unsigned IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic [NUM_IN-1:0] req,
  output logic              found,
  output logic [IDX_W-1:0]  idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned NUM_IN    = 32,
  parameter logic [31:0] EDGE_MASK = 32'hFFFF_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_IN-1:0]    irq_in,
  input  logic [WADDR_W-1:0]   bus_waddr,
  input  logic                 bus_wr,
  input  logic [WORD_W-1:0]    bus_wdata,
  input  logic                 bus_rd,
  output logic [WORD_W-1:0]    bus_rdata,
  output logic                 bus_rvalid,
  output logic                 irq_out
);

  localparam int unsigned IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
  localparam logic [NUM_IN-1:0] EDGE_V = EDGE_MASK[NUM_IN-1:0];

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_ni = rst_sync_q[1];

  vic_reg_e            sel;
  logic [NUM_IN-1:0]   wmask;
  logic [NUM_IN-1:0]   en_q;
  logic [NUM_IN-1:0]   en_d;
  logic                en_we;
  logic [1:0]          mer_q;
  logic [1:0]          mer_d;
  logic                mer_we;
  logic [NUM_IN-1:0]   ack_mask;
  logic [NUM_IN-1:0]   stat;
  logic [NUM_IN-1:0]   pend;
  logic                vec_found;
  logic [IDX_W-1:0]    vec_idx;
  logic [WORD_W-1:0]   vec_w;
  logic [WORD_W-1:0]   rd_d;
  logic [WORD_W-1:0]   rdata_q;
  logic                rvalid_q;

  assign sel   = vic_reg_e'(bus_waddr);
  assign wmask = bus_wdata[NUM_IN-1:0];

  // enable and master next-state
  always_comb begin
    en_we  = 1'b0;
    en_d   = en_q;
    mer_we = 1'b0;
    mer_d  = mer_q;
    if (bus_wr) begin
      unique case (sel)
        RG_EN:     begin en_we = 1'b1; en_d = wmask;          end
        RG_SETEN:  begin en_we = 1'b1; en_d = en_q | wmask;   end
        RG_CLREN:  begin en_we = 1'b1; en_d = en_q & ~wmask;  end
        RG_MASTER: begin mer_we = 1'b1; mer_d = bus_wdata[1:0]; end
        default:   begin end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      mer_q <= 2'b00;
    end else begin
      if (en_we)  en_q  <= en_d;
      if (mer_we) mer_q <= mer_d;
    end
  end

  // acknowledge only when armed
  always_comb begin
    ack_mask = '0;
    if (bus_wr && (sel == RG_ACK) && mer_q[1]) begin
      ack_mask = wmask;
    end
  end

  vic_capture #(
    .NUM_IN    (NUM_IN),
    .EDGE_MASK (EDGE_MASK)
  ) u_capture (
    .clk      (clk),
    .rst_n    (rst_ni),
    .irq_in   (irq_in),
    .ack_mask (ack_mask),
    .status   (stat)
  );

  assign pend = stat & en_q;

  vic_prio_enc #(
    .NUM_IN (NUM_IN)
  ) u_prio (
    .req   (pend),
    .found (vec_found),
    .idx   (vec_idx)
  );

  assign vec_w   = vec_found ? WORD_W'(vec_idx) : VEC_NONE;
  assign irq_out = mer_q[0] & (|pend);

  // read path
  always_comb begin
    unique case (sel)
      RG_STAT:   rd_d = WORD_W'(stat);
      RG_PEND:   rd_d = WORD_W'(pend);
      RG_EN:     rd_d = WORD_W'(en_q);
      RG_VEC:    rd_d = vec_w;
      RG_MASTER: rd_d = {{(WORD_W-2){1'b0}}, mer_q};
      default:   rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) rdata_q <= rd_d;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  logic [NUM_IN-1:0] below_idx;
  always_comb begin
    for (int i = 0; i < NUM_IN; i++) begin
      below_idx[i] = (i < int'(vec_idx));
    end
  end

  AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_ni) bus_rd |=> bus_rvalid); // R2
  AST_SETEN_KEEPS: assert property (@(posedge clk) disable iff (!rst_ni) (bus_wr && sel == RG_SETEN) |=> ((en_q & $past(en_q)) == $past(en_q))); // R3
  AST_CLREN_DROPS: assert property (@(posedge clk) disable iff (!rst_ni) (bus_wr && sel == RG_CLREN) |=> ((en_q & $past(wmask)) == '0)); // R3
  AST_ACK_BLOCKED: assert property (@(posedge clk) disable iff (!rst_ni) !mer_q[1] |=> (($past(stat) & EDGE_V & ~stat) == '0)); // R6
  AST_VEC_LOWEST: assert property (@(posedge clk) disable iff (!rst_ni) vec_found |-> (pend[vec_idx] && ((pend & below_idx) == '0))); // R8

endmodule

// File: tb/irq_vec_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vec_ctrl_bench;

  localparam int unsigned NI = 12;
  localparam logic [31:0] EM = 32'h0000_0F0F;
  localparam logic [2:0] A_STAT = 3'd0, A_PEND = 3'd1, A_EN = 3'd2, A_ACK = 3'd3,
                         A_SETEN = 3'd4, A_CLREN = 3'd5, A_VEC = 3'd6, A_MER = 3'd7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NI-1:0] irq_in = '0;
  logic [2:0]    bus_waddr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic          irq_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  irq_vec_ctrl #(.NUM_IN(NI), .EDGE_MASK(EM)) u_irq_vec_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_waddr(bus_waddr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq_out(irq_out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total = total + 1;
    if (got !== exp) begin
      bad = bad + 1;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_waddr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_waddr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    if (bus_rvalid !== 1'b1) chk("R2 rvalid", {31'b0, bus_rvalid}, 32'h1);
    d = bus_rdata;
  endtask

  task automatic pulse(input int b);
    @(negedge clk);
    irq_in[b] = 1'b1;
    @(negedge clk);
    irq_in[b] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq_out", {31'b0, irq_out}, 32'h0);
    chk("R1 rvalid", {31'b0, bus_rvalid}, 32'h0);
    rd(A_EN, v);  chk("R1 enable", v, 32'h0);
    rd(A_MER, v); chk("R1 master", v, 32'h0);
    rd(A_STAT, v); chk("R1 status", v, 32'h0);
    rd(A_VEC, v); chk("R1 vector", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    wr(A_EN, 32'h0F0);    rd(A_EN, v); chk("R3 load", v, 32'h0F0);
    wr(A_SETEN, 32'h00F); rd(A_EN, v); chk("R3 set", v, 32'h0FF);
    wr(A_CLREN, 32'h030); rd(A_EN, v); chk("R3 clear", v, 32'h0CF);
    wr(A_EN, 32'hFFFF_FFFF); rd(A_EN, v); chk("R10 upper enable", v, 32'hFFF);
    rd(A_SETEN, v); chk("R10 setenable reads zero", v, 32'h0);
    wr(A_EN, 32'h0); rd(A_EN, v); chk("R3 zero", v, 32'h0);
  endtask

  task automatic t_master();
    logic [31:0] v;
    wr(A_MER, 32'hFFFF_FFFF); rd(A_MER, v); chk("R9 both", v, 32'h3);
    wr(A_MER, 32'h1); rd(A_MER, v); chk("R9 bit0", v, 32'h1);
    wr(A_MER, 32'h2); rd(A_MER, v); chk("R9 bit1", v, 32'h2);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(A_MER, 32'h3); wr(A_EN, 32'hFFF);
    pulse(1);
    rd(A_STAT, v); chk("R4 latched", v, 32'h002);
    chk("R7 irq_out", {31'b0, irq_out}, 32'h1);
    rd(A_VEC, v); chk("R8 vec 1", v, 32'h1);
    pulse(9);
    rd(A_STAT, v); chk("R4 two latched", v, 32'h202);
    rd(A_VEC, v); chk("R8 lowest", v, 32'h1);
    wr(A_ACK, 32'h002);
    rd(A_STAT, v); chk("R6 ack one", v, 32'h200);
    rd(A_VEC, v); chk("R8 vec 9", v, 32'h9);
    wr(A_ACK, 32'h0);
    rd(A_STAT, v); chk("R6 ack zeros", v, 32'h200);
    wr(A_ACK, 32'hFFFF_FFFF);
    rd(A_STAT, v); chk("R6 ack all", v, 32'h0);
    rd(A_VEC, v); chk("R8 none", v, 32'hFFFF_FFFF);
    chk("R7 irq low", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_hie();
    logic [31:0] v;
    wr(A_MER, 32'h1);
    pulse(2);
    wr(A_ACK, 32'h004);
    rd(A_STAT, v); chk("R6 ack unarmed", v, 32'h004);
    chk("R7 irq with ME", {31'b0, irq_out}, 32'h1);
    wr(A_MER, 32'h2);
    chk("R7 irq gated by ME", {31'b0, irq_out}, 32'h0);
    wr(A_MER, 32'h3);
    wr(A_ACK, 32'h004);
    rd(A_STAT, v); chk("R6 ack armed", v, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    @(negedge clk); irq_in[5] = 1'b1;
    @(negedge clk);
    chk("R5 follows", {31'b0, irq_out}, 32'h1);
    rd(A_STAT, v); chk("R5 status", v, 32'h020);
    @(negedge clk);
    bus_waddr = A_ACK; bus_wdata = 32'h020; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R5 ack dip", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    chk("R5 ack return", {31'b0, irq_out}, 32'h1);
    wr(A_EN, 32'h0);
    rd(A_PEND, v); chk("R7 pending masked", v, 32'h0);
    rd(A_STAT, v); chk("R7 status unmasked", v, 32'h020);
    rd(A_VEC, v); chk("R8 none masked", v, 32'hFFFF_FFFF);
    chk("R7 irq masked", {31'b0, irq_out}, 32'h0);
    wr(A_EN, 32'hFFF);
    @(negedge clk); irq_in[5] = 1'b0;
    @(negedge clk);
    rd(A_STAT, v); chk("R5 drops", v, 32'h0);
  endtask

  task automatic t_readonly();
    logic [31:0] v;
    pulse(0);
    wr(A_STAT, 32'h0);
    wr(A_PEND, 32'h0);
    wr(A_VEC, 32'hFFFF_FFFF);
    rd(A_STAT, v); chk("R10 status kept", v, 32'h001);
    rd(A_EN, v); chk("R10 enable kept", v, 32'hFFF);
    rd(A_MER, v); chk("R10 master kept", v, 32'h3);
    rd(A_ACK, v); chk("R10 ack reads zero", v, 32'h0);
    wr(A_ACK, 32'h001);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    pulse(3);
    @(negedge clk);
    irq_in[3] = 1'b1;
    bus_waddr = A_ACK; bus_wdata = 32'h008; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; irq_in[3] = 1'b0;
    rd(A_STAT, v); chk("R4 rise beats ack", v, 32'h008);
    wr(A_ACK, 32'h008);
    rd(A_STAT, v); chk("R4 later ack clears", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_enable();
    t_master();
    t_edge();
    t_hie();
    t_level();
    t_readonly();
    t_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule